// File: doc/BRIEF.md
# Banked Register File Addressing with Pin Port

This block turns the short address field of an 8-bit controller's instructions into full register-file accesses. An instruction names only seven address bits. The eighth bit, which picks one of two 128-byte banks, comes from a bank bit held in the status register. Operand 00h is not a storage location. It is an indirect window: an access there goes to the full 8-bit address held in a pointer register, in either bank. A few control registers are mirrored so that they appear at the same offset in both banks. These are the status register, the pointer, a 4-bit program-counter-high buffer and an interrupt-enable byte.

The block also owns a 7-bit output port on pin bits 7..1. Reading the port returns the live pin levels. Writing it loads an output latch. Because a read returns the pins, a core that changes one bit does so by read-modify-write. A per-bit enable register gates which latch bits drive their pins. A disabled bit is left undriven. A small general-purpose RAM window in each bank completes the map. Reads are combinational, and writes land on the next rising clock edge.

The address decode has no sequencing, so the block has no state machine. Its storage is a set of plain registers, and the decode selects among them with an enumerated target type.

Top module: `banked_regfile`

## Requirements
- R1: A direct access (operand not 00h) uses address {bank bit, operand[6:0]}. Bank bit 0 reaches 00h–7Fh and bank bit 1 reaches 80h–FFh. General RAM at offsets 20h–2Fh is separate storage in each bank.
- R2: The status register is at offset 03h in both banks and resets to 00h. Its bit 7 is the bank bit used by R1.
- R3: Operand 00h is indirect. It reads or writes the register whose full 8-bit address is in the pointer, whatever the bank bit.
- R4: The pointer register is at offset 04h in both banks. It has no reset value.
- R5: An indirect access whose pointer has low seven bits equal to 0 (00h or 80h) reads 00h, and a write through it changes nothing.
- R6: The program-counter-high buffer is at offset 0Ah in both banks and resets to 00h. It keeps wr_data[3:0] and reads with bits 7..4 as 0.
- R7: The interrupt-enable register is at offset 0Bh in both banks and resets to 00h.
- R8: A read of address 06h returns pin_in[7:1] in bits 7..1 and 0 in bit 0.
- R9: A write to address 06h loads port_q[7:1] from wr_data[7:1] on the next edge. port_q[0] is always 0, the latch resets to 00h, and pin levels never change it.
- R10: The enable register is at address 86h and resets to 00h. port_oe equals it, and bit 0 is always 0. A 0 bit leaves that pin undriven.
- R11: rd_data is combinational and reads 00h while rd_en is low. A read and a write to the same address in one cycle return the old value.
- R12: Unmapped addresses read 00h, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_addr | input | 7 | Address field of the instruction |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| pin_in | input | 8 | Pin levels (bit 0 unused) |
| rd_data | output | 8 | Combinational read data |
| port_q | output | 8 | Output latch, bit 0 zero |
| port_oe | output | 8 | Per-pin drive enable, bit 0 zero |

## Verification
The same operand (20h) is written and read under both bank bit values, which shows whether the bank bit reaches address bit 7. Indirect accesses use a pointer into the opposite bank, which shows whether pointer bit 7 overrides the bank bit. Pointers of 00h and 80h are used to show that the null window reads zero and ignores writes. The mirrored registers are written in one bank and read back in the other. The port is read with pin patterns that differ from the latch, which separates pin reads from latch contents. A same-cycle read and write shows that the read path is combinational and the write is registered.

// File: rtl/regf_pkg.sv
package regf_pkg;
    localparam int DW  = 8;
    localparam int AW  = 8;
    localparam int OPW = 7;

    localparam logic [OPW-1:0] OFS_STATUS = 7'h03;
    localparam logic [OPW-1:0] OFS_PTR    = 7'h04;
    localparam logic [OPW-1:0] OFS_PCH    = 7'h0A;
    localparam logic [OPW-1:0] OFS_INTEN  = 7'h0B;
    localparam logic [AW-1:0]  ADR_PORT   = 8'h06;
    localparam logic [AW-1:0]  ADR_PORTEN = 8'h86;

    typedef enum logic [2:0] {
        T_NONE,
        T_STATUS,
        T_PTR,
        T_PORT,
        T_PORTEN,
        T_PCH,
        T_INTEN,
        T_RAM
    } tgt_e;
endpackage

// File: rtl/regf_addr_gen.sv
module regf_addr_gen
    import regf_pkg::*;
(
    input  logic [OPW-1:0] op_addr,
    input  logic           bank,
    input  logic [AW-1:0]  ptr,
    output logic [AW-1:0]  eff_addr,
    output logic           is_null
);
    logic indirect;

    always_comb begin
        indirect = (op_addr == '0);
        eff_addr = indirect ? ptr : {bank, op_addr};
        // an effective address on the indirect slot itself is a null access
        is_null  = (eff_addr[OPW-1:0] == '0);
    end
endmodule

// File: rtl/regf_decode.sv
module regf_decode
    import regf_pkg::*;
#(
    parameter logic [6:0] RAM_BASE  = 7'h20,
    parameter int         RAM_WORDS = 16,
    localparam int        IW        = $clog2(RAM_WORDS)
) (
    input  logic [AW-1:0] eff_addr,
    input  logic          is_null,
    output tgt_e          tgt,
    output logic [IW:0]   ram_idx
);
    logic [OPW-1:0] low;
    logic [OPW-1:0] off;
    logic           in_ram;

    always_comb begin
        low     = eff_addr[OPW-1:0];
        off     = low - RAM_BASE;
        in_ram  = (low >= RAM_BASE) && (off < OPW'(RAM_WORDS));
        ram_idx = {eff_addr[AW-1], off[IW-1:0]};
        if (is_null)                    tgt = T_NONE;
        else if (low == OFS_STATUS)     tgt = T_STATUS;
        else if (low == OFS_PTR)        tgt = T_PTR;
        else if (low == OFS_PCH)        tgt = T_PCH;
        else if (low == OFS_INTEN)      tgt = T_INTEN;
        else if (eff_addr == ADR_PORT)  tgt = T_PORT;
        else if (eff_addr == ADR_PORTEN) tgt = T_PORTEN;
        else if (in_ram)                tgt = T_RAM;
        else                            tgt = T_NONE;
    end
endmodule

// File: rtl/regf_port.sv
module regf_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_latch,
    input  logic         wr_enable,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] port_q,
    output logic [W-1:0] port_oe,
    output logic [W-1:0] pin_rd
);
    localparam logic [W-1:0] MASK = {{(W-1){1'b1}}, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q  <= '0;
            port_oe <= '0;
        end else begin
            if (wr_latch)  port_q  <= wr_data & MASK;
            if (wr_enable) port_oe <= wr_data & MASK;
        end
    end

    assign pin_rd = pin_in & MASK;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regf_pkg::*;
#(
    parameter logic [6:0] RAM_BASE  = 7'h20,
    parameter int         RAM_WORDS = 16,
    parameter int         PCHW      = 4,
    parameter int         BANK_BIT  = 7,
    localparam int        IW        = $clog2(RAM_WORDS),
    localparam int        DEPTH     = 2 * RAM_WORDS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_addr,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    input  logic [DW-1:0]  pin_in,
    output logic [DW-1:0]  rd_data,
    output logic [DW-1:0]  port_q,
    output logic [DW-1:0]  port_oe
);
    logic [DW-1:0]   status_q;
    logic [AW-1:0]   ptr_q;
    logic [PCHW-1:0] pch_q;
    logic [DW-1:0]   inten_q;
    logic [DW-1:0]   ram_q [DEPTH];
    logic [AW-1:0]   eff_addr;
    logic            is_null;
    tgt_e            tgt;
    logic [IW:0]     ram_idx;
    logic [DW-1:0]   pin_rd;

    regf_addr_gen u_agen (
        .op_addr  (op_addr),
        .bank     (status_q[BANK_BIT]),
        .ptr      (ptr_q),
        .eff_addr (eff_addr),
        .is_null  (is_null)
    );

    regf_decode #(.RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS)) u_dec (
        .eff_addr (eff_addr),
        .is_null  (is_null),
        .tgt      (tgt),
        .ram_idx  (ram_idx)
    );

    regf_port #(.W(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_latch  (wr_en && tgt == T_PORT),
        .wr_enable (wr_en && tgt == T_PORTEN),
        .wr_data   (wr_data),
        .pin_in    (pin_in),
        .port_q    (port_q),
        .port_oe   (port_oe),
        .pin_rd    (pin_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            pch_q    <= '0;
            inten_q  <= '0;
        end else if (wr_en) begin
            if (tgt == T_STATUS) status_q <= wr_data;
            if (tgt == T_PCH)    pch_q    <= wr_data[PCHW-1:0];
            if (tgt == T_INTEN)  inten_q  <= wr_data;
        end
    end

    // pointer and RAM carry no reset: their power-up content is undefined
    always_ff @(posedge clk) begin
        if (wr_en && tgt == T_PTR) ptr_q <= wr_data;
        if (wr_en && tgt == T_RAM) ram_q[ram_idx] <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (tgt)
                T_NONE:   rd_data = '0;
                T_STATUS: rd_data = status_q;
                T_PTR:    rd_data = ptr_q;
                T_PORT:   rd_data = pin_rd;
                T_PORTEN: rd_data = port_oe;
                T_PCH:    rd_data = DW'(pch_q);
                T_INTEN:  rd_data = inten_q;
                T_RAM:    rd_data = ram_q[ram_idx];
            endcase
        end
    end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] op_addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] pin_in,
    input logic [7:0] rd_data,
    input logic [7:0] port_q,
    input logic [7:0] port_oe,
    input logic [7:0] status_q
);
    p_port_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_q[0] == 1'b0);

    p_oe_bit0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        port_oe[0] == 1'b0);

    p_port_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_addr == 7'h06 && !status_q[7]) |=> port_q[7:1] == $past(wr_data[7:1]));

    p_port_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(port_q));

    p_oe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(port_oe));

    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == 8'h00);

    p_port_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && op_addr == 7'h06 && !status_q[7]) |-> rd_data == {pin_in[7:1], 1'b0});

    p_status_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_addr == 7'h03) |=> status_q == $past(wr_data));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_addr  (op_addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pin_in   (pin_in),
    .rd_data  (rd_data),
    .port_q   (port_q),
    .port_oe  (port_oe),
    .status_q (status_q)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    localparam int CLK_NS = 20;
    localparam int NV     = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] op_addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] rd_data, port_q, port_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .pin_in(pin_in),
        .rd_data(rd_data), .port_q(port_q), .port_oe(port_oe)
    );

    // {write, operand, wdata, pins, expected read, requirement number}
    localparam logic [35:0] VECS [NV] = '{
        {1'b1, 7'h20, 8'hAA, 8'h00, 8'h00, 4'd1},  // R1 bank 0 RAM
        {1'b0, 7'h20, 8'h00, 8'h00, 8'hAA, 4'd1},
        {1'b1, 7'h03, 8'h80, 8'h00, 8'h00, 4'd2},  // R2 select bank 1
        {1'b0, 7'h03, 8'h00, 8'h00, 8'h80, 4'd2},  // R2 read via 83h
        {1'b1, 7'h20, 8'h55, 8'h00, 8'h00, 4'd1},  // R1 A0h
        {1'b0, 7'h20, 8'h00, 8'h00, 8'h55, 4'd1},
        {1'b1, 7'h03, 8'h00, 8'h00, 8'h00, 4'd2},  // R2 back to bank 0
        {1'b0, 7'h20, 8'h00, 8'h00, 8'hAA, 4'd1},  // R1 banks are separate
        {1'b1, 7'h04, 8'hA0, 8'h00, 8'h00, 4'd4},  // R4 pointer = A0h
        {1'b0, 7'h00, 8'h00, 8'h00, 8'h55, 4'd3},  // R3 indirect into bank 1
        {1'b1, 7'h00, 8'h3C, 8'h00, 8'h00, 4'd3},
        {1'b1, 7'h03, 8'h80, 8'h00, 8'h00, 4'd2},
        {1'b0, 7'h20, 8'h00, 8'h00, 8'h3C, 4'd3},  // R3 write landed in A0h
        {1'b0, 7'h04, 8'h00, 8'h00, 8'hA0, 4'd4},  // R4 mirror at 84h
        {1'b1, 7'h04, 8'h80, 8'h00, 8'h00, 4'd5},  // R5 pointer 80h
        {1'b1, 7'h00, 8'hFF, 8'h00, 8'h00, 4'd5},
        {1'b0, 7'h00, 8'h00, 8'h00, 8'h00, 4'd5},
        {1'b1, 7'h04, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 pointer 00h
        {1'b0, 7'h00, 8'h00, 8'h00, 8'h00, 4'd5},
        {1'b1, 7'h0A, 8'h5A, 8'h00, 8'h00, 4'd6},  // R6 write at 8Ah
        {1'b1, 7'h03, 8'h00, 8'h00, 8'h00, 4'd2},
        {1'b0, 7'h0A, 8'h00, 8'h00, 8'h0A, 4'd6},  // R6 read at 0Ah
        {1'b1, 7'h0B, 8'hC5, 8'h00, 8'h00, 4'd7},  // R7 write at 0Bh
        {1'b1, 7'h03, 8'h80, 8'h00, 8'h00, 4'd2},
        {1'b0, 7'h0B, 8'h00, 8'h00, 8'hC5, 4'd7},  // R7 read at 8Bh
        {1'b1, 7'h06, 8'h3F, 8'h00, 8'h00, 4'd10}, // R10 enables at 86h
        {1'b0, 7'h06, 8'h00, 8'hFF, 8'h3E, 4'd10},
        {1'b1, 7'h03, 8'h00, 8'h00, 8'h00, 4'd2},
        {1'b1, 7'h06, 8'hA5, 8'h00, 8'h00, 4'd9},  // R9 latch write
        {1'b0, 7'h06, 8'h00, 8'h5B, 8'h5A, 4'd8},  // R8 pins, not latch
        {1'b1, 7'h10, 8'h77, 8'h00, 8'h00, 4'd12}, // R12 unmapped
        {1'b0, 7'h10, 8'h00, 8'h00, 8'h00, 4'd12}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL R0 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        #2;
        check("R11 idle read", rd_data, 8'h00);
        check("R9 latch reset", port_q, 8'h00);
        check("R10 enable reset", port_oe, 8'h00);
        rd_en = 1'b1; op_addr = 7'h03; #2;
        check("R2 status reset", rd_data, 8'h00);
        op_addr = 7'h0A; #2;
        check("R6 buffer reset", rd_data, 8'h00);
        op_addr = 7'h0B; #2;
        check("R7 enable reset", rd_data, 8'h00);
        rd_en = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = VECS[i][35];
            rd_en   = !VECS[i][35];
            op_addr = VECS[i][34:28];
            wr_data = VECS[i][27:20];
            pin_in  = VECS[i][19:12];
            #2;
            if (!VECS[i][35])
                check($sformatf("R%0d vector %0d", VECS[i][3:0], i), rd_data, VECS[i][11:4]);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #2;
        check("R9 latch value", port_q, 8'hA4);
        check("R10 drive enables", port_oe, 8'h3E);
        pin_in = 8'hFF;
        @(negedge clk); #2;
        check("R9 pins leave latch", port_q, 8'hA4);

        // R11: same-cycle read and write return the old value
        op_addr = 7'h20; wr_data = 8'h11; wr_en = 1'b1; rd_en = 1'b1; #2;
        check("R11 old value", rd_data, 8'hAA);
        @(negedge clk);
        wr_en = 1'b0; #2;
        check("R11 new value", rd_data, 8'h11);
        rd_en = 1'b0; #2;
        check("R11 idle read", rd_data, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule